// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block connects a byte-wide host register port to a set of internal register banks that have no address space of their own. The host sees three registers. A control byte selects the target bank and turns on auto-increment. An offset byte selects a location within that bank. A data byte carries writes to the bank and returns reads from it. A write to the data byte becomes a single downstream bank write in the same cycle. A read of the data byte returns the selected bank's byte combinationally in that same host cycle.

Each bank has its own legal offset window, and the digital page has two separate windows. The bridge refuses any data access outside the selected window. Such an access makes no downstream write, and a read returns zero. One select code broadcasts a data write to all four link-channel banks at once. When auto-increment is on, a run of data accesses walks through consecutive offsets without the host reprogramming the offset byte.

Top module: `ireg_bridge`

## Requirements
- R1: After a synchronous active-low reset, the control and offset registers read 0x00 and no downstream write or read strobe is active.
- R2: The control register is at host address 0xB0. Bits [5:2] are the bank select and bit 1 enables auto-increment. Bits 7:6 and bit 0 read as zero and ignore writes (writing 0xFF reads back 0x3E).
- R3: The offset register is at host address 0xB1. It reads back the last byte written to it.
- R4: A host write to the data address 0xB2 with an in-range offset pulses exactly one bank write enable in the same cycle. The pulse is bit N of `dn_wr_en` for select code N, and it carries the current offset and the written byte.
- R5: A host read of 0xB2 with an in-range offset returns the selected bank's byte at the current offset in the same cycle.
- R6: Select code 0 (digital page) accepts offsets 0x01–0x1F and 0x40–0x48 only. Offsets 0x00, 0x20 and 0x49 are refused.
- R7: Codes 1–4 accept 0x00–0x14, code 5 accepts 0x00–0x04, code 7 accepts 0x00–0x1D, and codes 8–15 accept no offset.
- R8: A refused data access produces no downstream write, and a refused data read returns 0x00.
- R9: Under code 6, an in-range data write (0x00–0x14) pulses the write enables of banks 1–4 together (`dn_wr_en` = 0x1E). A data read under code 6 returns bank 1's byte.
- R10: With auto-increment on, every data read or write advances the offset by one on the following clock edge. This holds for refused accesses too, and 0xFF wraps to 0x00.
- R11: With auto-increment off, data accesses leave the offset unchanged.
- R12: Host accesses to any other address change no register, produce no downstream write and read back 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_en | input | 1 | Host access strobe, one access per cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Host register address |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid in the cycle of a read strobe |
| dn_wr_en | output | 8 | Per-bank write enable, bit N for bank N |
| dn_ofs | output | 8 | Offset presented to the banks |
| dn_wdata | output | 8 | Byte written to the banks |
| dn_rd_en | output | 1 | Bank read strobe for an in-range data read |
| dn_rd_bank | output | 4 | Bank whose byte is read |
| dn_rdata | input | 8 | Byte returned by the addressed bank |

## Verification
Downstream write enables, the offset and write byte, and the host read byte all depend combinationally on the current host strobe. The bench therefore samples them a few nanoseconds after driving the strobe on the falling edge, before the rising edge that completes the access. Register updates and the auto-increment take effect on that rising edge, so they are checked by a host read in a later cycle. One such read is made in the very next cycle, which shows the incremented offset is due exactly one edge after the data access. The bench's bank model commits writes on the rising edge, so the result of a write is read back one cycle after it.

// File: rtl/ireg_pkg.sv
// Package: shared constants and types for the indirect register access bridge.
// Assumes byte-wide host data and byte-wide bank offsets.
package ireg_pkg;
    localparam int DW = 8;   // host and bank data width
    localparam int OW = 8;   // bank offset width
    localparam int SW = 4;   // bank select width

    localparam logic [7:0] ADDR_CTL = 8'hB0;
    localparam logic [7:0] ADDR_OFS = 8'hB1;
    localparam logic [7:0] ADDR_DAT = 8'hB2;

    // select codes whose behaviour is special
    localparam logic [SW-1:0] CODE_DIGITAL = 4'd0;
    localparam logic [SW-1:0] CODE_SHARED  = 4'd5;
    localparam logic [SW-1:0] CODE_BCAST   = 4'd6;
    localparam logic [SW-1:0] CODE_TXCSI   = 4'd7;

    // decoded host access for one cycle
    typedef struct packed {
        logic ctl_we;
        logic ofs_we;
        logic dat_wr;
        logic dat_rd;
        logic ctl_rd;
        logic ofs_rd;
    } hacc_t;
endpackage

// File: rtl/ireg_decode.sv
// Module: ireg_decode
// Turns one host strobe into at most one decoded register access.
// Assumes one access per cycle; unknown addresses decode to nothing.
module ireg_decode
    import ireg_pkg::*;
(
    input  logic       hst_en,
    input  logic       hst_we,
    input  logic [7:0] hst_addr,
    output hacc_t      acc
);
    // address and direction decode
    always_comb begin
        acc = '0;
        if (hst_en) begin
            unique case (hst_addr)
                ADDR_CTL: begin
                    acc.ctl_we = hst_we;
                    acc.ctl_rd = !hst_we;
                end
                ADDR_OFS: begin
                    acc.ofs_we = hst_we;
                    acc.ofs_rd = !hst_we;
                end
                ADDR_DAT: begin
                    acc.dat_wr = hst_we;
                    acc.dat_rd = !hst_we;
                end
                default: acc = '0;
            endcase
        end
    end

    // R12: a strobe aimed elsewhere decodes to no access
    always_comb begin
        if (hst_en && hst_addr != ADDR_CTL && hst_addr != ADDR_OFS && hst_addr != ADDR_DAT)
            assert_other_none_R12: assert (acc == '0);
    end
endmodule

// File: rtl/ireg_regs.sv
// Module: ireg_regs
// Holds the control fields (bank select, auto-increment) and the offset register.
// Assumes offset writes and data accesses never share a cycle (one access per cycle).
module ireg_regs
    import ireg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  hacc_t         acc,
    input  logic [DW-1:0] wdata,
    output logic [SW-1:0] sel,
    output logic          autoinc,
    output logic [OW-1:0] ofs
);
    logic dat_acc;
    assign dat_acc = acc.dat_wr | acc.dat_rd;

    // control register: only select and auto-increment bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= '0;
            autoinc <= 1'b0;
        end else if (acc.ctl_we) begin
            sel     <= wdata[5:2];
            autoinc <= wdata[1];
        end
    end

    // offset register: host load, else step after a data access when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs <= '0;
        else if (acc.ofs_we)
            ofs <= wdata[OW-1:0];
        else if (dat_acc && autoinc)
            ofs <= ofs + 1'b1;
    end

    // R10: offset steps by one after a data access with auto-increment on
    assert_autoinc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dat_acc && autoinc && !acc.ofs_we) |-> ofs == $past(ofs) + 1'b1);

    // R11: offset holds across a data access with auto-increment off
    assert_offset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dat_acc && !autoinc && !acc.ofs_we) |-> $stable(ofs));

    // R2: control fields change only on a control write
    assert_ctl_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(acc.ctl_we) |-> $stable(sel) && $stable(autoinc));
endmodule

// File: rtl/ireg_range.sv
// Module: ireg_range
// Decides whether the current offset is legal in the selected page.
// Assumes unlisted select codes have no legal offsets.
module ireg_range
    import ireg_pkg::*;
#(
    parameter logic [OW-1:0] DIG_LO0  = 8'h01,
    parameter logic [OW-1:0] DIG_HI0  = 8'h1F,
    parameter logic [OW-1:0] DIG_LO1  = 8'h40,
    parameter logic [OW-1:0] DIG_HI1  = 8'h48,
    parameter logic [OW-1:0] LINK_TOP = 8'h14,
    parameter logic [OW-1:0] SHRD_TOP = 8'h04,
    parameter logic [OW-1:0] CSI_TOP  = 8'h1D
) (
    input  logic [SW-1:0] sel,
    input  logic [OW-1:0] ofs,
    output logic          in_range
);
    logic dig_ok;

    // digital page has two separate windows
    always_comb begin
        dig_ok = (ofs >= DIG_LO0 && ofs <= DIG_HI0) ||
                 (ofs >= DIG_LO1 && ofs <= DIG_HI1);
    end

    // per-code upper limits; all other pages start at zero
    always_comb begin
        unique case (sel)
            CODE_DIGITAL:               in_range = dig_ok;
            4'd1, 4'd2, 4'd3, 4'd4:     in_range = (ofs <= LINK_TOP);
            CODE_SHARED:                in_range = (ofs <= SHRD_TOP);
            CODE_BCAST:                 in_range = (ofs <= LINK_TOP);
            CODE_TXCSI:                 in_range = (ofs <= CSI_TOP);
            default:                    in_range = 1'b0;
        endcase
    end

    // R7: codes above 7 never pass
    always_comb begin
        if (sel > CODE_TXCSI)
            assert_high_codes_closed_R7: assert (!in_range);
    end
endmodule

// File: rtl/ireg_dnport.sv
// Module: ireg_dnport
// Drives the downstream bank interface: per-bank write enables, offset, data, read bank.
// Assumes banks sample a write on the clock edge ending the host cycle.
module ireg_dnport
    import ireg_pkg::*;
#(
    parameter int NBANK      = 8,
    parameter int LINK_FIRST = 1,
    parameter int LINK_COUNT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel,
    input  logic [OW-1:0]    ofs,
    input  logic             in_range,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [DW-1:0]    wdata,
    output logic [NBANK-1:0] wr_en,
    output logic [OW-1:0]    dn_ofs,
    output logic [DW-1:0]    dn_wdata,
    output logic             rd_en,
    output logic [SW-1:0]    rd_bank
);
    localparam int LINK_LAST = LINK_FIRST + LINK_COUNT - 1;
    localparam logic [NBANK-1:0] LINK_MASK =
        NBANK'(((1 << LINK_COUNT) - 1) << LINK_FIRST);

    logic wr_go;
    assign wr_go = dat_wr && in_range;

    // one enable per bank: direct match, or link bank under broadcast
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam bit IS_LINK  = (b >= LINK_FIRST) && (b <= LINK_LAST);
        localparam bit IS_BCAST = (b == int'(CODE_BCAST));
        logic hit;
        always_comb begin
            hit = (!IS_BCAST && sel == SW'(b)) ||
                  (IS_LINK && sel == CODE_BCAST);
        end
        assign wr_en[b] = wr_go && hit;
    end

    // offset and data pass straight through
    assign dn_ofs   = ofs;
    assign dn_wdata = wdata;

    // read bank: broadcast code reads the first link bank
    always_comb begin
        rd_en   = dat_rd && in_range;
        rd_bank = (sel == CODE_BCAST) ? SW'(LINK_FIRST) : sel;
    end

    // R8: refused offsets never write
    assert_oor_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> wr_en == '0);

    // R4: a non-broadcast write touches at most one bank
    assert_single_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel != CODE_BCAST |-> $countones(wr_en) <= 1);

    // R9: broadcast write reaches exactly the link banks
    assert_bcast_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr && in_range && sel == CODE_BCAST |-> wr_en == LINK_MASK);

    // R1: no write without a host data write
    assert_no_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |-> wr_en == '0);
endmodule

// File: rtl/ireg_bridge.sv
// Module: ireg_bridge (top)
// Host-facing control/offset/data registers reaching internal banks indirectly.
// Assumes the addressed bank returns dn_rdata combinationally from dn_rd_bank/dn_ofs.
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int NBANK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_en,
    input  logic             hst_we,
    input  logic [7:0]       hst_addr,
    input  logic [7:0]       hst_wdata,
    output logic [7:0]       hst_rdata,
    output logic [NBANK-1:0] dn_wr_en,
    output logic [7:0]       dn_ofs,
    output logic [7:0]       dn_wdata,
    output logic             dn_rd_en,
    output logic [3:0]       dn_rd_bank,
    input  logic [7:0]       dn_rdata
);
    hacc_t         acc;
    logic [SW-1:0] sel;
    logic          autoinc;
    logic [OW-1:0] ofs;
    logic          in_range;

    ireg_decode u_dec (
        .hst_en   (hst_en),
        .hst_we   (hst_we),
        .hst_addr (hst_addr),
        .acc      (acc)
    );

    ireg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wdata   (hst_wdata),
        .sel     (sel),
        .autoinc (autoinc),
        .ofs     (ofs)
    );

    ireg_range u_rng (
        .sel      (sel),
        .ofs      (ofs),
        .in_range (in_range)
    );

    ireg_dnport #(.NBANK(NBANK)) u_dn (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .ofs      (ofs),
        .in_range (in_range),
        .dat_wr   (acc.dat_wr),
        .dat_rd   (acc.dat_rd),
        .wdata    (hst_wdata),
        .wr_en    (dn_wr_en),
        .dn_ofs   (dn_ofs),
        .dn_wdata (dn_wdata),
        .rd_en    (dn_rd_en),
        .rd_bank  (dn_rd_bank)
    );

    // host read mux: reserved control bits read zero, refused data reads zero
    always_comb begin
        hst_rdata = '0;
        if (acc.ctl_rd)
            hst_rdata = {2'b00, sel, autoinc, 1'b0};
        else if (acc.ofs_rd)
            hst_rdata = ofs;
        else if (acc.dat_rd && in_range)
            hst_rdata = dn_rdata;
    end

    // R2: control readback right after a control write returns the written fields
    assert_ctl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(acc.ctl_we) && acc.ctl_rd |->
            hst_rdata == {2'b00, $past(hst_wdata[5:1]), 1'b0});

    // R8: a refused data read returns zero
    assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc.dat_rd && !dn_rd_en |-> hst_rdata == 8'h00);

    // R12: strobes elsewhere read zero
    assert_other_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hst_en && !hst_we && hst_addr != ADDR_CTL && hst_addr != ADDR_OFS &&
        hst_addr != ADDR_DAT |-> hst_rdata == 8'h00);
endmodule

// File: tb/sim_ireg_bridge.sv
// Directed bench for ireg_bridge: one task per scenario, banks modelled as byte arrays.
module sim_ireg_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_en = 1'b0;
    logic       hst_we = 1'b0;
    logic [7:0] hst_addr = 8'h00;
    logic [7:0] hst_wdata = 8'h00;
    logic [7:0] hst_rdata;
    logic [7:0] dn_wr_en;
    logic [7:0] dn_ofs;
    logic [7:0] dn_wdata;
    logic       dn_rd_en;
    logic [3:0] dn_rd_bank;
    logic [7:0] dn_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] mem [8][256];
    logic [7:0] s_rd, s_wen, s_ofs, s_wd;

    always #10 clk = ~clk;   // 50 MHz

    ireg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .dn_wr_en(dn_wr_en), .dn_ofs(dn_ofs), .dn_wdata(dn_wdata),
        .dn_rd_en(dn_rd_en), .dn_rd_bank(dn_rd_bank), .dn_rdata(dn_rdata)
    );

    // bank model: combinational read, write on rising edge
    assign dn_rdata = (dn_rd_bank < 4'd8) ? mem[dn_rd_bank[2:0]][dn_ofs] : 8'h00;
    always @(posedge clk) begin
        for (int b = 0; b < 8; b++)
            if (dn_wr_en[b]) mem[b][dn_ofs] <= dn_wdata;
    end

    function automatic logic [7:0] seed(int b, int o);
        return 8'((b * 37) + (o * 3) + 1);
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one host access; snapshot outputs before the completing edge
    task automatic acc(bit we, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        hst_en = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
        #4;
        s_rd = hst_rdata; s_wen = dn_wr_en; s_ofs = dn_ofs; s_wd = dn_wdata;
        @(posedge clk);
        #1 hst_en = 1'b0; hst_we = 1'b0;
    endtask

    task automatic t_reset();
        #4; chk("R1 write idle", dn_wr_en, 8'h00);
        chk("R1 read idle", {7'd0, dn_rd_en}, 8'h00);
        acc(0, 8'hB0, 0); chk("R1 ctl", s_rd, 8'h00);
        acc(0, 8'hB1, 0); chk("R1 ofs", s_rd, 8'h00);
    endtask

    task automatic t_ctl();
        acc(1, 8'hB0, 8'hFF); acc(0, 8'hB0, 0); chk("R2 reserved", s_rd, 8'h3E);
        acc(1, 8'hB0, 8'h1C); acc(0, 8'hB0, 0); chk("R2 fields", s_rd, 8'h1C);
    endtask

    task automatic t_ofs();
        acc(1, 8'hB1, 8'hA5); acc(0, 8'hB1, 0); chk("R3 ofs", s_rd, 8'hA5);
    endtask

    task automatic t_write();
        acc(1, 8'hB0, 8'h04); acc(1, 8'hB1, 8'h10);
        acc(1, 8'hB2, 8'h5A);
        chk("R4 enable", s_wen, 8'h02);
        chk("R4 offset", s_ofs, 8'h10);
        chk("R4 data", s_wd, 8'h5A);
        acc(0, 8'hB2, 0); chk("R5 readback", s_rd, 8'h5A);
    endtask

    task automatic t_read();
        acc(1, 8'hB0, 8'h1C); acc(1, 8'hB1, 8'h1D);
        acc(0, 8'hB2, 0); chk("R5 csi page", s_rd, seed(7, 'h1D));
    endtask

    task automatic probe(string req, logic [7:0] code, logic [7:0] o, bit ok);
        acc(1, 8'hB0, 8'(code << 2)); acc(1, 8'hB1, o);
        acc(1, 8'hB2, 8'h99);
        chk(req, s_wen, ok ? 8'(1 << code) & 8'hFF : 8'h00);
    endtask

    task automatic t_digital();
        probe("R6 0x00", 0, 8'h00, 0);
        probe("R6 0x01", 0, 8'h01, 1);
        probe("R6 0x1F", 0, 8'h1F, 1);
        probe("R6 0x20", 0, 8'h20, 0);
        probe("R6 0x40", 0, 8'h40, 1);
        probe("R6 0x48", 0, 8'h48, 1);
        probe("R6 0x49", 0, 8'h49, 0);
    endtask

    task automatic t_limits();
        probe("R7 shared 04", 5, 8'h04, 1);
        probe("R7 shared 05", 5, 8'h05, 0);
        probe("R7 link1 14", 2, 8'h14, 1);
        probe("R7 link1 15", 2, 8'h15, 0);
        probe("R7 csi 1E", 7, 8'h1E, 0);
        probe("R7 code9", 9, 8'h00, 0);
    endtask

    task automatic t_oor();
        acc(1, 8'hB0, 8'h04); acc(1, 8'hB1, 8'h30);
        acc(1, 8'hB2, 8'hEE); chk("R8 no write", s_wen, 8'h00);
        acc(0, 8'hB2, 0); chk("R8 read zero", s_rd, 8'h00);
    endtask

    task automatic t_bcast();
        acc(1, 8'hB0, 8'h18); acc(1, 8'hB1, 8'h08);
        acc(1, 8'hB2, 8'hC3); chk("R9 mask", s_wen, 8'h1E);
        acc(0, 8'hB2, 0); chk("R9 read link0", s_rd, 8'hC3);
        acc(1, 8'hB0, 8'h10); acc(0, 8'hB2, 0); chk("R9 bank4", s_rd, 8'hC3);
        acc(1, 8'hB0, 8'h00); acc(0, 8'hB2, 0); chk("R9 digital untouched", s_rd, seed(0, 8));
    endtask

    task automatic t_autoinc();
        acc(1, 8'hB0, 8'h06); acc(1, 8'hB1, 8'h12);
        acc(1, 8'hB2, 8'h11); chk("R10 first ofs", s_ofs, 8'h12);
        acc(0, 8'hB1, 0); chk("R10 next cycle", s_rd, 8'h13);
        acc(1, 8'hB2, 8'h22); acc(1, 8'hB2, 8'h33); chk("R10 third ofs", s_ofs, 8'h14);
        acc(1, 8'hB2, 8'h44); chk("R10 oor write", s_wen, 8'h00);
        acc(0, 8'hB1, 0); chk("R10 after oor", s_rd, 8'h16);
        acc(1, 8'hB1, 8'h13); acc(0, 8'hB2, 0); chk("R10 read seq", s_rd, 8'h22);
        acc(0, 8'hB2, 0); chk("R10 read seq2", s_rd, 8'h33);
        acc(1, 8'hB1, 8'hFF); acc(0, 8'hB2, 0);
        acc(0, 8'hB1, 0); chk("R10 wrap", s_rd, 8'h00);
    endtask

    task automatic t_noinc();
        acc(1, 8'hB0, 8'h04); acc(1, 8'hB1, 8'h03);
        acc(1, 8'hB2, 8'h01); acc(0, 8'hB2, 0);
        acc(0, 8'hB1, 0); chk("R11 hold", s_rd, 8'h03);
    endtask

    task automatic t_other();
        acc(1, 8'hB3, 8'h77); chk("R12 no write", s_wen, 8'h00);
        acc(1, 8'hAF, 8'hFF);
        acc(0, 8'hB0, 0); chk("R12 ctl kept", s_rd, 8'h04);
        acc(0, 8'hB1, 0); chk("R12 ofs kept", s_rd, 8'h03);
        acc(0, 8'hB3, 0); chk("R12 read zero", s_rd, 8'h00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int b = 0; b < 8; b++)
            for (int o = 0; o < 256; o++)
                mem[b][o] = seed(b, o);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ctl();
        t_ofs();
        t_write();
        t_read();
        t_digital();
        t_limits();
        t_oor();
        t_bcast();
        t_autoinc();
        t_noinc();
        t_other();
        done = 1;
        summary();
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule